// File: doc/BRIEF.md
# Six-Line Edge-Triggered Interrupt Controller

The block gathers six active-high request lines, numbered 2 through 7, and hands one request at a time to a processor. Each line first passes a two-flop synchronizer. A low-to-high transition then latches a pending request for that line. Each line has a disable bit in a byte-wide register that software can read back. Among the pending lines that are enabled, the lowest-numbered line wins. While a winner is offered, the interrupt output stays high and the vector output shows 0x08 plus the line number.

The processor takes the request with a single-cycle acknowledge. That pulse clears the winner's pending bit and sets an in-service flag. While the flag is set, no further request is offered, even if other lines are pending. Software ends service by writing the command byte 0x20 to port address 0x20, which clears the flag. The disable register sits at port address 0x21. Bits 2 to 7 govern lines 2 to 7, and bits 0 and 1 are plain storage.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the disable register reads 0xFF, `int_o` is low, `vec_o` is 0x00 and nothing is pending or in service.
- R2: A line's request becomes pending only on a low-to-high transition. `irq_req_i[k]` stands for line k+2. After a rise is driven before clock edge 1, the pending state takes effect at edge 3. Holding a line high, or a falling transition, raises no new request.
- R3: In the register at address 0x21, bit n disables line n when 1 and enables it when 0. A disabled line's rise is still kept pending and is offered once the bit is cleared.
- R4: A read strobe loads `reg_rdata_o` at the next edge, and the value holds until the next strobe. Address 0x21 returns all eight bits as stored, including bits 0 and 1. Any other address returns 0x00.
- R5: Among the pending, enabled lines, the lowest-numbered line is offered first.
- R6: While `int_o` is high, `vec_o` equals 0x08 plus the offered line number (0x0A to 0x0F). While `int_o` is low, `vec_o` is 0x00.
- R7: An acknowledge while `int_o` is high clears the offered line's pending bit and enters service. `int_o` stays low while in service. An acknowledge while `int_o` is low has no effect.
- R8: Writing 0x20 to address 0x20 ends service. Any other value written to that address is ignored.
- R9: Repeated rises on a line that is already pending merge into one request.
- R10: A rise on a line that lands in the same cycle as the acknowledge of that line leaves the line pending again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | 6 | Request lines; bit k is line k+2 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register port address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, registered |
| int_o | output | 1 | Interrupt to the processor |
| int_ack_i | input | 1 | Single-cycle acknowledge |
| vec_o | output | 8 | Vector of the offered line |

## Verification
Two events can fall in the same cycle: the acknowledge that clears a line's pending bit, and a fresh synchronized rise on that same line. The bench provokes this by driving the line high two cycles before the acknowledge pulse, so that the edge detector fires on the acknowledge edge. The outcome is judged after the command byte ends service: the line must be offered again with its vector. Every cycle is also compared against a behavioural model, so a dropped or duplicated request shows up at once.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int unsigned NUM_LINES   = 6;
  localparam int unsigned FIRST_LINE  = 2;
  localparam int unsigned SYNC_STAGES = 2;
  localparam int unsigned IDX_W       = $clog2(NUM_LINES);
  localparam logic [7:0]  VEC_BASE    = 8'h08;
  localparam logic [7:0]  ADDR_CMD    = 8'h20;
  localparam logic [7:0]  ADDR_MASK   = 8'h21;
  localparam logic [7:0]  CODE_EOI    = 8'h20;
  localparam logic [7:0]  MASK_RST    = 8'hFF;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
  parameter int unsigned N      = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] rise_o
);
  for (genvar g = 0; g < N; g++) begin : g_line
    // STAGES sync flops plus one history flop
    logic [STAGES:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-1:0], req_i[g]};
    end
    assign rise_o[g] = chain_q[STAGES-1] & ~chain_q[STAGES];
  end
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N     = 6,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     cand_i,
  output logic             vld_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest index wins: scan downward so the last hit is the lowest
  always_comb begin
    vld_o = 1'b0;
    idx_o = '0;
    for (int i = int'(N) - 1; i >= 0; i--) begin
      if (cand_i[i]) begin
        vld_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_reg_port.sv
module irq_reg_port
  import prio_irq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic       rd_i,
  input  logic [7:0] addr_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] mask_o,
  output logic [7:0] rdata_o,
  output logic       eoi_o
);
  logic [7:0] mask_q, rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q  <= MASK_RST;
      rdata_q <= '0;
    end else begin
      if (wr_i && addr_i == ADDR_MASK) mask_q <= wdata_i;
      if (rd_i) rdata_q <= (addr_i == ADDR_MASK) ? mask_q : 8'h00;
    end
  end

  assign eoi_o   = wr_i && addr_i == ADDR_CMD && wdata_i == CODE_EOI;
  assign mask_o  = mask_q;
  assign rdata_o = rdata_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_req_i,
  input  logic                 reg_wr_i,
  input  logic                 reg_rd_i,
  input  logic [7:0]           reg_addr_i,
  input  logic [7:0]           reg_wdata_i,
  output logic [7:0]           reg_rdata_o,
  output logic                 int_o,
  input  logic                 int_ack_i,
  output logic [7:0]           vec_o
);
  logic [NUM_LINES-1:0] rise, pend_q, pend_d, cand, take_mask;
  logic [7:0]           mask_q;
  logic                 eoi, insvc_q, win_vld, take;
  logic [IDX_W-1:0]     win_idx;

  irq_edge_detect #(.N(NUM_LINES), .STAGES(SYNC_STAGES)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (irq_req_i),
    .rise_o (rise)
  );

  irq_reg_port u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .rd_i    (reg_rd_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .mask_o  (mask_q),
    .rdata_o (reg_rdata_o),
    .eoi_o   (eoi)
  );

  assign cand = pend_q & ~mask_q[FIRST_LINE +: NUM_LINES];

  irq_prio_pick #(.N(NUM_LINES), .IDX_W(IDX_W)) u_pick (
    .cand_i (cand),
    .vld_o  (win_vld),
    .idx_o  (win_idx)
  );

  assign int_o     = win_vld & ~insvc_q;
  assign vec_o     = int_o ? VEC_BASE + 8'(FIRST_LINE) + 8'(win_idx) : 8'h00;
  assign take      = int_o & int_ack_i;
  assign take_mask = take ? (NUM_LINES'(1) << win_idx) : '0;
  // a fresh edge outranks the clear from the acknowledge
  assign pend_d    = (pend_q & ~take_mask) | rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= '0;
      insvc_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
      if (take)     insvc_q <= 1'b1;
      else if (eoi) insvc_q <= 1'b0;
    end
  end
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk
  import prio_irq_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input logic       int_o,
  input logic       int_ack_i,
  input logic [7:0] vec_o,
  input logic       reg_wr_i,
  input logic       reg_rd_i,
  input logic [7:0] reg_addr_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic [7:0] mask_q,
  input logic       insvc_q
);
  logic eoi_wr;
  assign eoi_wr = reg_wr_i && reg_addr_i == ADDR_CMD && reg_wdata_i == CODE_EOI;

  // R7
  ack_drops_int_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_o && int_ack_i) |=> !int_o);

  // R8
  svc_held_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (insvc_q && !eoi_wr) |=> insvc_q);

  // R8
  eoi_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eoi_wr |=> !insvc_q);

  // R6
  vec_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> (vec_o >= 8'h0A && vec_o <= 8'h0F));

  // R3
  masked_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_o |-> !mask_q[vec_o[2:0]]);

  // R4
  readback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_rd_i && reg_addr_i == ADDR_MASK) |=> reg_rdata_o == $past(mask_q));
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .int_o       (int_o),
  .int_ack_i   (int_ack_i),
  .vec_o       (vec_o),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .mask_q      (mask_q),
  .insvc_q     (insvc_q)
);

// File: tb/prio_irq_ctrl_tb.sv
`timescale 1ns/1ps
module prio_irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] irq = '0;
  logic       wr = 1'b0, rd = 1'b0, ack = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata, vec;
  logic       intr;
  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  prio_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(irq),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .int_o(intr), .int_ack_i(ack), .vec_o(vec)
  );

  // behavioural reference model
  int  m_hist[6][$];
  bit  m_pend[6];
  int  m_mask, m_rdata;
  bit  m_svc;

  function automatic int m_win();
    for (int k = 0; k < 6; k++)
      if (m_pend[k] && !m_mask[k+2]) return k;
    return -1;
  endfunction
  function automatic bit m_int();
    return (m_win() >= 0) && !m_svc;
  endfunction
  function automatic int m_vec();
    return m_int() ? 8 + 2 + m_win() : 0;
  endfunction

  task automatic m_reset();
    for (int k = 0; k < 6; k++) begin
      m_hist[k] = '{0, 0, 0};
      m_pend[k] = 1'b0;
    end
    m_mask = 8'hFF; m_rdata = 0; m_svc = 1'b0;
  endtask

  initial m_reset();

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_reset();
    else begin
      bit rose[6];
      int w;
      int old_mask;
      for (int k = 0; k < 6; k++) rose[k] = m_hist[k][1] == 1 && m_hist[k][2] == 0;
      w = m_win();
      if (ack && m_int()) begin m_pend[w] = 1'b0; m_svc = 1'b1; end
      else if (wr && addr == 8'h20 && wdata == 8'h20) m_svc = 1'b0;
      for (int k = 0; k < 6; k++) if (rose[k]) m_pend[k] = 1'b1;
      old_mask = m_mask;
      if (wr && addr == 8'h21) m_mask = wdata;
      if (rd) m_rdata = (addr == 8'h21) ? old_mask : 0;
      for (int k = 0; k < 6; k++) begin
        void'(m_hist[k].pop_back());
        m_hist[k].push_front(int'(irq[k]));
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      total++;
      if (intr !== m_int() || vec !== 8'(m_vec()) || rdata !== 8'(m_rdata)) begin
        bad++;
        $display("FAIL R7 model compare: int=%0b vec=%02h rdata=%02h exp int=%0b vec=%02h rdata=%02h",
                 intr, vec, rdata, m_int(), m_vec(), m_rdata);
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    wr = 1'b1; addr = a; wdata = d; @(negedge clk); wr = 1'b0;
  endtask
  task automatic reg_read(input logic [7:0] a);
    rd = 1'b1; addr = a; @(negedge clk); rd = 1'b0;
  endtask
  task automatic pulse_ack();
    ack = 1'b1; @(negedge clk); ack = 1'b0;
  endtask

  task automatic finish_up();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<20000", cyc);
      finish_up();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    chk("R1 int after reset", intr, 0);
    chk("R1 vec after reset", vec, 0);
    reg_read(8'h21);
    chk("R1 mask after reset", rdata, 8'hFF);

    // masked rise held pending
    irq[1] = 1'b1; idle(5);
    chk("R3 masked line silent", intr, 0);
    reg_write(8'h21, 8'hF7);
    chk("R3 unmasked line offered", intr, 1);
    chk("R6 vector line3", vec, 8'h0B);
    reg_read(8'h21);
    chk("R4 readback", rdata, 8'hF7);
    reg_read(8'h22);
    chk("R4 other address", rdata, 8'h00);
    reg_write(8'h21, 8'hF4);
    reg_read(8'h21);
    chk("R4 low bits stored", rdata, 8'hF4);

    pulse_ack();
    chk("R7 in service", intr, 0);
    reg_write(8'h21, 8'h00);
    irq[0] = 1'b1; irq[3] = 1'b1; idle(5);
    chk("R7 held while in service", intr, 0);
    reg_write(8'h20, 8'h10);
    chk("R8 wrong code ignored", intr, 0);
    reg_write(8'h20, 8'h20);
    chk("R8 eoi releases", intr, 1);
    chk("R5 lowest line wins", vec, 8'h0A);
    pulse_ack(); reg_write(8'h20, 8'h20);
    chk("R6 vector line5", vec, 8'h0D);
    pulse_ack(); reg_write(8'h20, 8'h20);
    chk("R2 held high no new request", intr, 0);

    // merge on line 7
    irq[5] = 1'b1; idle(4); irq[5] = 1'b0; idle(4); irq[5] = 1'b1; idle(5);
    chk("R9 line7 offered", vec, 8'h0F);
    pulse_ack(); reg_write(8'h20, 8'h20);
    chk("R9 merged to one", intr, 0);

    // falling edges raise nothing
    irq = '0; idle(6);
    chk("R2 fall no request", intr, 0);
    pulse_ack(); idle(1);
    chk("R7 stray ack ignored", intr, 0);

    // rise on line 6 meeting its own acknowledge
    irq[4] = 1'b1; idle(5); irq[4] = 1'b0; idle(4);
    chk("R10 line6 pending", vec, 8'h0E);
    irq[4] = 1'b1; idle(2);
    pulse_ack();
    chk("R10 taken", intr, 0);
    reg_write(8'h20, 8'h20);
    chk("R10 repended", intr, 1);
    chk("R10 vector", vec, 8'h0E);
    pulse_ack(); reg_write(8'h20, 8'h20);
    chk("R10 single extra", intr, 0);

    idle(3);
    finish_up();
  end
endmodule